// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the address stream for a DMA channel that walks a one- or two-dimensional element pattern. A start pulse captures the channel settings: base address, element size, signed row and column modifiers, row and column counts, flow mode and row-interrupt enable. The block then asks for one element at a time. Each response reports how many bytes the data path moved. A full element advances the address by the signed X modifier and consumes one column slot. A zero-byte response is treated as a stall and is retried after a back-off period. Any other byte count is an error.

At the end of a row, a 2D walk with rows remaining moves to the next row. The address correction undoes the last column step and applies the row modifier. When the last row ends, the flow mode decides what happens next. The channel can stop, restart the same pattern at once, or ask a descriptor unit for new settings and wait for them. The data path itself is outside this block.

Top module: `dma2d_seq`

## Requirements
- R1: After reset the channel is idle: `running`, `xferReq`, `done`, `err`, `strideErr`, `rowIrq` and `descReq` are 0, and the address and counters are 0.
- R2: A `start` pulse latches the settings and loads `curAddr` with the base address, `curXCount` with the X count and `curYCount` with the Y count. A count of 0 loads 0xFFFF. From the next cycle `running` and `xferReq` are 1. `start` also clears `done` and `err`.
- R3: A response carrying exactly one element of bytes adds the sign-extended 16-bit X modifier to `curAddr` and lowers `curXCount` by one. Element size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 1 byte.
- R4: When settings are loaded and the magnitude of the X modifier is not the element size, `strideErr` is set and the channel stays or becomes idle.
- R5: When the column count reaches zero with the interrupt enable set, `rowIrq` is high for the single cycle after that response.
- R6: In 2D mode, when the column count reaches zero with `curYCount` > 1, `curYCount` drops by one and `curXCount` reloads. `curAddr` becomes the stepped address minus the X modifier plus the Y modifier.
- R7: At the end of the last row in flow mode 0 (stop), `running` falls, `done` is set, `curAddr` keeps the final step and `curXCount` reads 0.
- R8: At the end of the last row in flow mode 1 (repeat), the channel reloads the base address and both counts and keeps running.
- R9: At the end of the last row in flow modes 2 and 3 (descriptor), `descReq` pulses for one cycle and `xferReq` stays low. A `descValid` pulse then reloads the settings from the inputs, with the same rules as `start`.
- R10: A response whose byte count is neither zero nor one element sets `err` and stops the channel.
- R11: A zero-byte response holds `xferReq` low for `backoffCycles` cycles, or for 5000 cycles when `backoffCycles` is 0, and then raises it again. The address and counters are unchanged.
- R12: `xferResp` has no effect while `xferReq` is low (idle, backing off or waiting for a descriptor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load settings and begin |
| cfgMode2d | input | 1 | Two-dimensional walk enable |
| cfgFlow | input | 2 | Flow mode: 0 stop, 1 repeat, 2/3 descriptor |
| cfgIrqEn | input | 1 | Row-end interrupt enable |
| cfgElemSize | input | 2 | Element size code |
| cfgStartAddr | input | 32 | Base address |
| cfgXCount | input | 16 | Elements per row |
| cfgXModify | input | 16 | Signed column step in bytes |
| cfgYCount | input | 16 | Number of rows |
| cfgYModify | input | 16 | Signed row step in bytes |
| backoffCycles | input | 16 | Stall retry delay, 0 selects the default |
| xferResp | input | 1 | Data path response strobe |
| xferBytes | input | 3 | Bytes moved by this response |
| descValid | input | 1 | New descriptor settings present |
| xferReq | output | 1 | Request for the next element |
| curAddr | output | 32 | Current element address |
| curXCount | output | 16 | Remaining elements in the row |
| curYCount | output | 16 | Remaining rows |
| running | output | 1 | Channel active |
| done | output | 1 | Stop-mode completion flag |
| err | output | 1 | Bad response byte count flag |
| strideErr | output | 1 | Unsupported X modifier flag |
| rowIrq | output | 1 | One-cycle row-end interrupt |
| descReq | output | 1 | One-cycle descriptor reload request |

## Verification
A corrupted counter or address register is visible on the same cycle edge as the response that caused it, because `curAddr` and the counters are ports. A row-end error appears one response later as a wrong `curYCount` or a missing `rowIrq`. A wrong control state shows at once as `xferReq` asserted during a back-off or descriptor wait, or as an early or late rise after a stall. The bench therefore compares every output against its model on every clock. It also measures the back-off length in cycles.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  localparam int BYTES_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_BACKOFF,
    ST_WAITDESC
  } seqState_t;

  localparam logic [1:0] FLOW_STOP   = 2'd0;
  localparam logic [1:0] FLOW_REPEAT = 2'd1;

  // strobes from control to datapath, highest priority first
  typedef struct packed {
    logic load;
    logic autoReload;
    logic rowStep;
    logic step;
  } dpStrobe_t;

  function automatic logic [BYTES_W-1:0] elemBytes(input logic [1:0] code);
    case (code)
      2'd1:    elemBytes = BYTES_W'(2);
      2'd2:    elemBytes = BYTES_W'(4);
      default: elemBytes = BYTES_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/dmaseq_backoff.sv
module dmaseq_backoff #(
  parameter int CNT_W          = 16,
  parameter int DEFAULT_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic [CNT_W-1:0] cycles,
  output logic             expire
);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] loadVal;

  assign loadVal = (cycles == '0) ? CNT_W'(DEFAULT_CYCLES) : cycles;
  assign expire  = (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (arm) begin
      remain <= loadVal;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/dmaseq_dpath.sv
module dmaseq_dpath
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cfgMode2d,
  input  logic [1:0]        cfgFlow,
  input  logic              cfgIrqEn,
  input  logic [1:0]        cfgElemSize,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [CNT_W-1:0]  cfgXCount,
  input  logic [MOD_W-1:0]  cfgXModify,
  input  logic [CNT_W-1:0]  cfgYCount,
  input  logic [MOD_W-1:0]  cfgYModify,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  curX,
  output logic [CNT_W-1:0]  curY,
  output logic              lastX,
  output logic              moreRows,
  output logic [1:0]        flowQ,
  output logic              irqEnQ,
  output logic [BYTES_W-1:0] elemBytesQ,
  output logic              inStrideOk
);

  localparam int EXT_W = ADDR_W - MOD_W;

  logic [ADDR_W-1:0] startQ;
  logic [CNT_W-1:0]  xLenQ, yLenQ;
  logic [MOD_W-1:0]  xModQ, yModQ;
  logic              mode2dQ;
  logic [MOD_W-1:0]  absMod;
  logic [ADDR_W-1:0] xStep, yStep;
  logic [CNT_W-1:0]  xLenIn, yLenIn;

  assign xLenIn = (cfgXCount == '0) ? '1 : cfgXCount;
  assign yLenIn = (cfgYCount == '0) ? '1 : cfgYCount;

  assign absMod     = cfgXModify[MOD_W-1] ? (~cfgXModify + 1'b1) : cfgXModify;
  assign inStrideOk = (absMod == MOD_W'(elemBytes(cfgElemSize)));

  assign xStep = {{EXT_W{xModQ[MOD_W-1]}}, xModQ};
  assign yStep = {{EXT_W{yModQ[MOD_W-1]}}, yModQ};

  assign lastX    = (curX == CNT_W'(1));
  assign moreRows = mode2dQ && (curY > CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ     <= '0;
      xLenQ      <= '0;
      yLenQ      <= '0;
      xModQ      <= '0;
      yModQ      <= '0;
      mode2dQ    <= 1'b0;
      flowQ      <= FLOW_STOP;
      irqEnQ     <= 1'b0;
      elemBytesQ <= BYTES_W'(1);
    end else if (strobe.load) begin
      startQ     <= cfgStartAddr;
      xLenQ      <= xLenIn;
      yLenQ      <= yLenIn;
      xModQ      <= cfgXModify;
      yModQ      <= cfgYModify;
      mode2dQ    <= cfgMode2d;
      flowQ      <= cfgFlow;
      irqEnQ     <= cfgIrqEn;
      elemBytesQ <= elemBytes(cfgElemSize);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curX    <= '0;
      curY    <= '0;
    end else if (strobe.load) begin
      curAddr <= cfgStartAddr;
      curX    <= xLenIn;
      curY    <= yLenIn;
    end else if (strobe.autoReload) begin
      curAddr <= startQ;
      curX    <= xLenQ;
      curY    <= yLenQ;
    end else if (strobe.rowStep) begin
      // step then undo the column step: net effect is the row step alone
      curAddr <= curAddr + yStep;
      curX    <= xLenQ;
      curY    <= curY - 1'b1;
    end else if (strobe.step) begin
      curAddr <= curAddr + xStep;
      curX    <= curX - 1'b1;
    end
  end

endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               xferResp,
  input  logic [BYTES_W-1:0] xferBytes,
  input  logic               descValid,
  input  logic               lastX,
  input  logic               moreRows,
  input  logic [1:0]         flowQ,
  input  logic               irqEnQ,
  input  logic [BYTES_W-1:0] elemBytesQ,
  input  logic               inStrideOk,
  input  logic               backoffExpire,
  output logic               backoffArm,
  output dpStrobe_t          strobe,
  output logic               xferReq,
  output logic               running,
  output logic               done,
  output logic               err,
  output logic               strideErr,
  output logic               rowIrq,
  output logic               descReq
);

  seqState_t state, stateNext;
  logic doneNext, errNext, strideErrNext, irqNext, descNext;
  logic accept, goodElem, zeroResp;

  assign accept   = (state == ST_ACTIVE) && xferResp;
  assign goodElem = accept && (xferBytes == elemBytesQ);
  assign zeroResp = accept && (xferBytes == '0);

  assign xferReq = (state == ST_ACTIVE);
  assign running = (state != ST_IDLE);

  always_comb begin
    stateNext     = state;
    doneNext      = done;
    errNext       = err;
    strideErrNext = strideErr;
    irqNext       = 1'b0;
    descNext      = 1'b0;
    backoffArm    = 1'b0;
    strobe        = '0;

    if (start) begin
      doneNext      = 1'b0;
      errNext       = 1'b0;
      strideErrNext = !inStrideOk;
      strobe.load   = inStrideOk;
      stateNext     = inStrideOk ? ST_ACTIVE : ST_IDLE;
    end else begin
      unique case (state)
        ST_ACTIVE: begin
          if (goodElem) begin
            if (!lastX) begin
              strobe.step = 1'b1;
            end else begin
              irqNext = irqEnQ;
              if (moreRows) begin
                strobe.rowStep = 1'b1;
              end else if (flowQ == FLOW_STOP) begin
                strobe.step = 1'b1;
                doneNext    = 1'b1;
                stateNext   = ST_IDLE;
              end else if (flowQ == FLOW_REPEAT) begin
                strobe.autoReload = 1'b1;
              end else begin
                strobe.step = 1'b1;
                descNext    = 1'b1;
                stateNext   = ST_WAITDESC;
              end
            end
          end else if (zeroResp) begin
            backoffArm = 1'b1;
            stateNext  = ST_BACKOFF;
          end else if (accept) begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end
        end
        ST_BACKOFF: begin
          if (backoffExpire) stateNext = ST_ACTIVE;
        end
        ST_WAITDESC: begin
          if (descValid) begin
            strideErrNext = !inStrideOk;
            strobe.load   = inStrideOk;
            stateNext     = inStrideOk ? ST_ACTIVE : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      strideErr <= 1'b0;
      rowIrq    <= 1'b0;
      descReq   <= 1'b0;
    end else begin
      state     <= stateNext;
      done      <= doneNext;
      err       <= errNext;
      strideErr <= strideErrNext;
      rowIrq    <= irqNext;
      descReq   <= descNext;
    end
  end

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int CNT_W           = 16,
  parameter int MOD_W           = 16,
  parameter int BACKOFF_W       = 16,
  parameter int BACKOFF_DEFAULT = 5000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 cfgMode2d,
  input  logic [1:0]           cfgFlow,
  input  logic                 cfgIrqEn,
  input  logic [1:0]           cfgElemSize,
  input  logic [ADDR_W-1:0]    cfgStartAddr,
  input  logic [CNT_W-1:0]     cfgXCount,
  input  logic [MOD_W-1:0]     cfgXModify,
  input  logic [CNT_W-1:0]     cfgYCount,
  input  logic [MOD_W-1:0]     cfgYModify,
  input  logic [BACKOFF_W-1:0] backoffCycles,
  input  logic                 xferResp,
  input  logic [BYTES_W-1:0]   xferBytes,
  input  logic                 descValid,
  output logic                 xferReq,
  output logic [ADDR_W-1:0]    curAddr,
  output logic [CNT_W-1:0]     curXCount,
  output logic [CNT_W-1:0]     curYCount,
  output logic                 running,
  output logic                 done,
  output logic                 err,
  output logic                 strideErr,
  output logic                 rowIrq,
  output logic                 descReq
);

  dpStrobe_t          strobe;
  logic               lastX, moreRows, irqEnQ, inStrideOk;
  logic               backoffArm, backoffExpire;
  logic [1:0]         flowQ;
  logic [BYTES_W-1:0] elemBytesQ;

  dmaseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .xferResp(xferResp),
    .xferBytes(xferBytes), .descValid(descValid), .lastX(lastX),
    .moreRows(moreRows), .flowQ(flowQ), .irqEnQ(irqEnQ),
    .elemBytesQ(elemBytesQ), .inStrideOk(inStrideOk),
    .backoffExpire(backoffExpire), .backoffArm(backoffArm),
    .strobe(strobe), .xferReq(xferReq), .running(running), .done(done),
    .err(err), .strideErr(strideErr), .rowIrq(rowIrq), .descReq(descReq)
  );

  dmaseq_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgMode2d(cfgMode2d),
    .cfgFlow(cfgFlow), .cfgIrqEn(cfgIrqEn), .cfgElemSize(cfgElemSize),
    .cfgStartAddr(cfgStartAddr), .cfgXCount(cfgXCount),
    .cfgXModify(cfgXModify), .cfgYCount(cfgYCount), .cfgYModify(cfgYModify),
    .curAddr(curAddr), .curX(curXCount), .curY(curYCount), .lastX(lastX),
    .moreRows(moreRows), .flowQ(flowQ), .irqEnQ(irqEnQ),
    .elemBytesQ(elemBytesQ), .inStrideOk(inStrideOk)
  );

  dmaseq_backoff #(.CNT_W(BACKOFF_W), .DEFAULT_CYCLES(BACKOFF_DEFAULT)) u_backoff (
    .clk(clk), .rstN(rstN), .arm(backoffArm), .cycles(backoffCycles),
    .expire(backoffExpire)
  );

endmodule

// File: rtl/dma2d_seq_chk.sv
module dma2d_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              descValid,
  input logic              xferReq,
  input logic              xferResp,
  input logic [2:0]        xferBytes,
  input logic [ADDR_W-1:0] curAddr,
  input logic [CNT_W-1:0]  curXCount,
  input logic              running,
  input logic              done,
  input logic              err,
  input logic              rowIrq,
  input logic              descReq
);

  // R3: a mid-row element lowers the column count by one (or is an error)
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferResp && xferBytes != 3'd0 && !start && curXCount > CNT_W'(1))
      |=> ((curXCount == $past(curXCount) - 1'b1) || err));

  // R5: an interrupt only follows an accepted response
  a_r5_irq_after_resp: assert property (@(posedge clk) disable iff (!rstN)
    rowIrq |-> $past(xferReq && xferResp));

  // R7: a completed channel is not running
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!running && !xferReq));

  // R9: while asking for a descriptor the channel requests no element
  a_r9_desc_wait: assert property (@(posedge clk) disable iff (!rstN)
    descReq |-> (running && !xferReq));

  // R10: an error stops the channel
  a_r10_err_halts: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !running);

  // R11: a stall drops the request on the next cycle
  a_r11_stall_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferResp && xferBytes == 3'd0 && !start) |=> !xferReq);

  // R12: without a request, start or descriptor the address holds
  a_r12_hold_when_unrequested: assert property (@(posedge clk) disable iff (!rstN)
    (!xferReq && !start && !descValid) |=> $stable(curAddr));

endmodule

bind dma2d_seq dma2d_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_dma2d_seq.sv
`timescale 1ns/1ps
module test_dma2d_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        cfgMode2d = 1'b0;
  logic [1:0]  cfgFlow = 2'd0;
  logic        cfgIrqEn = 1'b0;
  logic [1:0]  cfgElemSize = 2'd0;
  logic [31:0] cfgStartAddr = '0;
  logic [15:0] cfgXCount = '0, cfgXModify = '0, cfgYCount = '0, cfgYModify = '0;
  logic [15:0] backoffCycles = '0;
  logic        xferResp = 1'b0;
  logic [2:0]  xferBytes = '0;
  logic        descValid = 1'b0;
  logic        xferReq, running, done, err, strideErr, rowIrq, descReq;
  logic [31:0] curAddr;
  logic [15:0] curXCount, curYCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma2d_seq i_dma2d_seq (.*);

  // ---------------- behavioural reference model ----------------
  int          mState;            // 0 idle, 1 active, 2 backoff, 3 wait descriptor
  logic [31:0] mAddr, mStart;
  int          mX, mY, mXLen, mYLen, mXMod, mYMod, mBytes, mFlow, mCnt;
  bit          m2d, mIrqEn, mDone, mErr, mStrErr, mIrq, mDesc;

  function automatic int sizeOf(input logic [1:0] c);
    return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
  endfunction

  task automatic modelLoad();
    int xm;
    xm = int'($signed(cfgXModify));
    if (xm < 0) xm = -xm;
    mStrErr = (xm != sizeOf(cfgElemSize));
    if (mStrErr) begin
      mState = 0;
    end else begin
      mState = 1;
      mStart = cfgStartAddr;
      mAddr  = cfgStartAddr;
      mXLen  = (cfgXCount == 0) ? 65535 : int'(cfgXCount);
      mYLen  = (cfgYCount == 0) ? 65535 : int'(cfgYCount);
      mX = mXLen; mY = mYLen;
      mXMod = int'($signed(cfgXModify));
      mYMod = int'($signed(cfgYModify));
      mBytes = sizeOf(cfgElemSize);
      mFlow = int'(cfgFlow);
      m2d = cfgMode2d; mIrqEn = cfgIrqEn;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mAddr = 0; mStart = 0; mX = 0; mY = 0; mXLen = 0; mYLen = 0;
      mXMod = 0; mYMod = 0; mBytes = 1; mFlow = 0; mCnt = 0;
      m2d = 0; mIrqEn = 0; mDone = 0; mErr = 0; mStrErr = 0; mIrq = 0; mDesc = 0;
    end else begin
      mIrq = 0; mDesc = 0;
      if (start) begin
        mDone = 0; mErr = 0;
        modelLoad();
      end else if (mState == 1) begin
        if (xferResp) begin
          if (int'(xferBytes) == mBytes) begin
            mAddr = mAddr + 32'(mXMod);
            mX = mX - 1;
            if (mX == 0) begin
              mIrq = mIrqEn;
              if (m2d && mY > 1) begin
                mY = mY - 1;
                mX = mXLen;
                mAddr = mAddr - 32'(mXMod) + 32'(mYMod);
              end else if (mFlow == 0) begin
                mDone = 1; mState = 0;
              end else if (mFlow == 1) begin
                mAddr = mStart; mX = mXLen; mY = mYLen;
              end else begin
                mDesc = 1; mState = 3;
              end
            end
          end else if (xferBytes == 0) begin
            mCnt = (backoffCycles == 0) ? 5000 : int'(backoffCycles);
            mState = 2;
          end else begin
            mErr = 1; mState = 0;
          end
        end
      end else if (mState == 2) begin
        mCnt = mCnt - 1;
        if (mCnt == 0) mState = 1;
      end else if (mState == 3) begin
        if (descValid) modelLoad();
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the model once per cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      nChecks++;
      if (curAddr !== mAddr) begin nFails++; $display("FAIL R3 curAddr actual=%0h expected=%0h", curAddr, mAddr); end
      if (curXCount !== 16'(mX)) begin nFails++; $display("FAIL R3 curXCount actual=%0h expected=%0h", curXCount, 16'(mX)); end
      if (curYCount !== 16'(mY)) begin nFails++; $display("FAIL R6 curYCount actual=%0h expected=%0h", curYCount, 16'(mY)); end
      if (running !== (mState != 0)) begin nFails++; $display("FAIL R2 running actual=%0b expected=%0b", running, mState != 0); end
      if (xferReq !== (mState == 1)) begin nFails++; $display("FAIL R11 xferReq actual=%0b expected=%0b", xferReq, mState == 1); end
      if (done !== mDone) begin nFails++; $display("FAIL R7 done actual=%0b expected=%0b", done, mDone); end
      if (err !== mErr) begin nFails++; $display("FAIL R10 err actual=%0b expected=%0b", err, mErr); end
      if (strideErr !== mStrErr) begin nFails++; $display("FAIL R4 strideErr actual=%0b expected=%0b", strideErr, mStrErr); end
      if (rowIrq !== mIrq) begin nFails++; $display("FAIL R5 rowIrq actual=%0b expected=%0b", rowIrq, mIrq); end
      if (descReq !== mDesc) begin nFails++; $display("FAIL R9 descReq actual=%0b expected=%0b", descReq, mDesc); end
    end
  end

  task automatic setCfg(input bit m2, input logic [1:0] fl, input bit ie, input logic [1:0] sz,
                        input logic [31:0] sa, input logic [15:0] xc, input logic [15:0] xm,
                        input logic [15:0] yc, input logic [15:0] ym);
    cfgMode2d = m2; cfgFlow = fl; cfgIrqEn = ie; cfgElemSize = sz;
    cfgStartAddr = sa; cfgXCount = xc; cfgXModify = xm; cfgYCount = yc; cfgYModify = ym;
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic resp(input logic [2:0] b);
    xferResp = 1'b1; xferBytes = b; @(negedge clk); xferResp = 1'b0; xferBytes = '0;
  endtask

  int lowCycles;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!running && !xferReq && !done && !err && !strideErr && !rowIrq && !descReq
        && curAddr == 0 && curXCount == 0, "R1 reset idle", {running, xferReq, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3/R7: 1D stop walk of 4-byte elements
    setCfg(0, 2'd0, 0, 2'd2, 32'h1000, 16'd3, 16'd4, 16'd1, 16'd0);
    pulseStart();
    chk(running && xferReq && curAddr == 32'h1000 && curXCount == 3, "R2 load", curAddr, 32'h1000);
    resp(3'd4);
    chk(curAddr == 32'h1004 && curXCount == 2, "R3 step", curAddr, 32'h1004);
    resp(3'd4); resp(3'd4);
    chk(done && !running && curAddr == 32'h100C && curXCount == 0, "R7 stop", curAddr, 32'h100C);

    // R5/R6: 2D walk with negative column step
    setCfg(1, 2'd0, 1, 2'd1, 32'h2000, 16'd2, 16'hFFFE, 16'd3, 16'h0020);
    pulseStart();
    chk(!done, "R2 start clears done", done, 0);
    resp(3'd2);
    chk(curAddr == 32'h1FFE, "R3 negative step", curAddr, 32'h1FFE);
    resp(3'd2);
    chk(curAddr == 32'h201E && curYCount == 2 && curXCount == 2, "R6 row step", curAddr, 32'h201E);
    chk(rowIrq, "R5 row interrupt", rowIrq, 1);
    repeat (4) resp(3'd2);
    chk(done && curAddr == 32'h2038 && curYCount == 1, "R7 2D done", curAddr, 32'h2038);

    // R8: repeat flow
    setCfg(0, 2'd1, 0, 2'd0, 32'h3000, 16'd2, 16'd1, 16'd1, 16'd0);
    pulseStart();
    resp(3'd1); resp(3'd1);
    chk(running && xferReq && curAddr == 32'h3000 && curXCount == 2, "R8 repeat reload", curAddr, 32'h3000);
    resp(3'd1);
    chk(curAddr == 32'h3001, "R8 continues", curAddr, 32'h3001);

    // R9/R12: descriptor flow
    setCfg(0, 2'd2, 0, 2'd0, 32'h4000, 16'd2, 16'd1, 16'd1, 16'd0);
    pulseStart();
    resp(3'd1); resp(3'd1);
    chk(descReq && !xferReq && running && curAddr == 32'h4002, "R9 desc request", curAddr, 32'h4002);
    resp(3'd1);
    chk(curAddr == 32'h4002 && curXCount == 0, "R12 ignored while waiting", curAddr, 32'h4002);
    setCfg(0, 2'd0, 0, 2'd0, 32'h5000, 16'd1, 16'd1, 16'd1, 16'd0);
    descValid = 1'b1; @(negedge clk); descValid = 1'b0;
    chk(xferReq && curAddr == 32'h5000 && curXCount == 1, "R9 desc reload", curAddr, 32'h5000);
    resp(3'd1);
    chk(done, "R9 new desc completes", done, 1);

    // R11/R12: stall with programmed back-off
    setCfg(0, 2'd0, 0, 2'd0, 32'h6000, 16'd4, 16'd1, 16'd1, 16'd0);
    backoffCycles = 16'd7;
    pulseStart();
    resp(3'd0);
    lowCycles = 1;
    resp(3'd1);
    chk(curAddr == 32'h6000 && curXCount == 4, "R12 ignored in backoff", curAddr, 32'h6000);
    while (!xferReq) begin lowCycles++; @(negedge clk); end
    chk(lowCycles == 7, "R11 backoff length", lowCycles, 7);
    resp(3'd1);
    chk(curAddr == 32'h6001, "R11 resumes", curAddr, 32'h6001);

    // R11: default back-off
    backoffCycles = 16'd0;
    resp(3'd0);
    lowCycles = 0;
    while (!xferReq && lowCycles < 6000) begin lowCycles++; @(negedge clk); end
    chk(lowCycles == 5000, "R11 default backoff", lowCycles, 5000);

    // R10: partial element
    setCfg(0, 2'd0, 0, 2'd2, 32'h7000, 16'd4, 16'd4, 16'd1, 16'd0);
    pulseStart();
    resp(3'd2);
    chk(err && !running && !xferReq && curAddr == 32'h7000, "R10 bad bytes", err, 1);
    resp(3'd4);
    chk(curAddr == 32'h7000, "R12 ignored when idle", curAddr, 32'h7000);

    // R4: unsupported stride
    setCfg(0, 2'd0, 0, 2'd1, 32'h8000, 16'd4, 16'd4, 16'd1, 16'd0);
    pulseStart();
    chk(strideErr && !running, "R4 stride rejected", strideErr, 1);

    // R2: zero counts load the maximum
    setCfg(1, 2'd0, 0, 2'd0, 32'h9000, 16'd0, 16'hFFFF, 16'd0, 16'd0);
    pulseStart();
    chk(!strideErr && curXCount == 16'hFFFF && curYCount == 16'hFFFF, "R2 zero count", curXCount, 16'hFFFF);
    resp(3'd1);
    chk(curAddr == 32'h8FFF, "R3 minus one step", curAddr, 32'h8FFF);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule